// File: doc/BRIEF.md
# APB Bus Protocol Rule Monitor

This block watches an APB-style peripheral bus and never drives it. Each clock edge it samples the select, enable, ready, address, write and write-data lines of the local requester. It also samples the select and enable lines of a second requester that shares the target. It judges five protocol rules.

For every rule the monitor raises a registered violation pulse and sets a sticky flag that stays set until reset. It also keeps a saturating counter of how often that rule's trigger condition occurred. A rule that never reports a violation can therefore be told apart from a rule whose trigger never fired.

The monitor is instantiated next to a bus segment, with its inputs tapped off the bus wires. Rule index r uses bit r of the pulse and sticky vectors and field r of the counter vector. The rule indices are:

| Index | Rule |
|---|---|
| 0 | enable ordering |
| 1 | setup-to-access |
| 2 | wait timeout |
| 3 | phase stability |
| 4 | peer exclusion |

Top module: `apb_rule_monitor`

## Requirements
- R1: When `enable` is high in a cycle where it was low the cycle before, and `sel` was low in that previous cycle, rule 0 reports a violation.
- R2: A setup cycle (`sel`=1, `enable`=0) that is not followed in the next cycle by an access cycle (`sel`=1, `enable`=1) makes rule 1 report a violation.
- R3: Consecutive access cycles of one transfer are numbered from offset 0. If `ready` is still low in the access cycle at offset 15 (the 16th), rule 2 reports a violation. If `ready` is high at any offset from 0 to 15, rule 2 reports nothing.
- R4: In an access cycle that directly follows a setup cycle, a difference in `addr` or `write` between the two cycles makes rule 3 report a violation.
- R5: If `write` was high in that setup cycle, a difference in `wdata` between the two cycles also makes rule 3 report a violation. If `write` was low, `wdata` has no effect.
- R6: A cycle in which both the local pair and the peer pair (`peer_sel`, `peer_enable`) are high makes rule 4 report a violation.
- R7: While `rst_n` is low, all pulses, sticky flags, counters and the cycle history are cleared at once (asynchronous clear), and no rule reports anything.
- R8: `viol_pulse[r]` is high for exactly the one cycle after each clock edge that sampled an offending cycle. `viol_sticky[r]` becomes set together with the pulse and stays set until reset.
- R9: `trig_count[16r+15:16r]` counts trigger cycles for rule r and saturates at 65535. The trigger for each rule is:
  - rule 0: a rising `enable`.
  - rule 1: the previous cycle was a setup cycle.
  - rule 2: the first access cycle of a transfer.
  - rule 3: an access cycle that follows a setup cycle.
  - rule 4: every local access cycle.
- R10: Rule 2 gives a single pulse per stalled transfer, however long the stall lasts. It re-arms once that transfer ends, either by `ready` in an access cycle or by the access phase being dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, suspends all checks |
| sel | input | 1 | Local peripheral select |
| enable | input | 1 | Local access-phase strobe |
| ready | input | 1 | Target ready (transfer completion) |
| addr | input | AW | Transfer address |
| write | input | 1 | Transfer direction, 1 = write |
| wdata | input | DW | Write data |
| peer_sel | input | 1 | Second requester select |
| peer_enable | input | 1 | Second requester access strobe |
| viol_pulse | output | 5 | One-cycle violation pulse per rule |
| viol_sticky | output | 5 | Sticky violation flag per rule |
| trig_count | output | 5*CW | Saturating trigger counters, CW bits per rule |

## Verification
The bench aims at the wait-limit boundary: `ready` arriving exactly at offset 15, and a stall that runs past it. A timer off by one would flag the legal case or miss the late one, and a timer that fails to latch would pulse on every extra stall cycle. It changes `wdata` during read transfers, where a checker that ignores direction would flag a false stability error. It drives enable without a prior select, a setup cycle that is abandoned, and overlapping peer access. It also applies reset in the middle of a stalled transfer, which catches history or timer state that survives reset. Finally, a long run of access cycles drives the exclusion counter past 65535, where a counter that wraps instead of saturating shows a small value.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;
  localparam int NRULE    = 5;
  localparam int RI_ORDER = 0;
  localparam int RI_SETUP = 1;
  localparam int RI_WAIT  = 2;
  localparam int RI_HOLD  = 3;
  localparam int RI_EXCL  = 4;
endpackage

// File: rtl/apb_mon_history.sv
module apb_mon_history #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          enable,
  input  logic [AW-1:0] addr,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  output logic          prev_sel,
  output logic          prev_enable,
  output logic [AW-1:0] prev_addr,
  output logic          prev_write,
  output logic [DW-1:0] prev_wdata
);
  logic          cap_en;
  logic [AW-1:0] addr_n;
  logic          write_n;
  logic [DW-1:0] wdata_n;

  // payload is only compared after a selected cycle, so capture only then
  always_comb begin
    cap_en  = sel;
    addr_n  = cap_en ? addr  : prev_addr;
    write_n = cap_en ? write : prev_write;
    wdata_n = cap_en ? wdata : prev_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel    <= 1'b0;
      prev_enable <= 1'b0;
      prev_addr   <= '0;
      prev_write  <= 1'b0;
      prev_wdata  <= '0;
    end else begin
      prev_sel    <= sel;
      prev_enable <= enable;
      prev_addr   <= addr_n;
      prev_write  <= write_n;
      prev_wdata  <= wdata_n;
    end
  end

  AST_PREV_SEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> prev_sel) else $error("prev_sel lost"); // R7
endmodule

// File: rtl/apb_mon_wait_timer.sv
module apb_mon_wait_timer #(
  parameter int WAIT_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic ready,
  output logic start,
  output logic timeout
);
  localparam int CNTW = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
  localparam logic [CNTW-1:0] LAST_OFS = CNTW'(WAIT_LIMIT - 1);

  logic            busy, busy_n;
  logic            expired, expired_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [CNTW-1:0] offset;
  logic            stall;

  always_comb begin
    offset  = busy ? cnt : '0;
    stall   = access & ~ready;
    start   = access & ~busy;
    timeout = stall & ~expired & (offset == LAST_OFS);
    if (stall) begin
      busy_n    = 1'b1;
      cnt_n     = (offset == LAST_OFS) ? offset : offset + CNTW'(1);
      expired_n = expired | timeout;
    end else begin
      busy_n    = 1'b0;
      cnt_n     = '0;
      expired_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      busy    <= busy_n;
      cnt     <= cnt_n;
      expired <= expired_n;
    end
  end

  AST_TIMEOUT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout) else $error("timeout repeated"); // R10
  AST_REARM_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (access && ready) |=> (!expired && start == access)) else $error("no re-arm"); // R10
endmodule

// File: rtl/apb_mon_rule_stat.sv
module apb_mon_rule_stat #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          bad,
  output logic          pulse,
  output logic          sticky,
  output logic [CW-1:0] count
);
  logic          cnt_en;
  logic [CW-1:0] count_n;
  logic          sticky_n;

  always_comb begin
    cnt_en   = hit & ~(&count);
    count_n  = cnt_en ? count + CW'(1) : count;
    sticky_n = sticky | bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
      count  <= '0;
    end else begin
      pulse  <= bad;
      sticky <= sticky_n;
      count  <= count_n;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sticky |=> sticky) else $error("sticky cleared"); // R8
  AST_PULSE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> sticky) else $error("pulse without sticky"); // R8
  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) |=> (&count)) else $error("counter wrapped"); // R9
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + CW'(1))) else $error("counter jump"); // R9
endmodule

// File: rtl/apb_rule_monitor.sv
module apb_rule_monitor
  import apb_mon_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int CW         = 16,
  parameter int WAIT_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              enable,
  input  logic              ready,
  input  logic [AW-1:0]     addr,
  input  logic              write,
  input  logic [DW-1:0]     wdata,
  input  logic              peer_sel,
  input  logic              peer_enable,
  output logic [NRULE-1:0]  viol_pulse,
  output logic [NRULE-1:0]  viol_sticky,
  output logic [NRULE*CW-1:0] trig_count
);
  logic          prev_sel, prev_enable, prev_write;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_wdata;
  logic          access, peer_access, was_setup, mismatch;
  logic          wt_start, wt_timeout;
  logic [NRULE-1:0] hit_vec, bad_vec;

  apb_mon_history #(.AW(AW), .DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .addr(addr),
    .write(write), .wdata(wdata), .prev_sel(prev_sel), .prev_enable(prev_enable),
    .prev_addr(prev_addr), .prev_write(prev_write), .prev_wdata(prev_wdata)
  );

  apb_mon_wait_timer #(.WAIT_LIMIT(WAIT_LIMIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .access(access), .ready(ready),
    .start(wt_start), .timeout(wt_timeout)
  );

  always_comb begin
    access      = sel & enable;
    peer_access = peer_sel & peer_enable;
    was_setup   = prev_sel & ~prev_enable;
    mismatch    = (addr != prev_addr) | (write != prev_write) |
                  (prev_write & (wdata != prev_wdata));

    hit_vec[RI_ORDER] = enable & ~prev_enable;
    bad_vec[RI_ORDER] = hit_vec[RI_ORDER] & ~prev_sel;
    hit_vec[RI_SETUP] = was_setup;
    bad_vec[RI_SETUP] = was_setup & ~access;
    hit_vec[RI_WAIT]  = wt_start;
    bad_vec[RI_WAIT]  = wt_timeout;
    hit_vec[RI_HOLD]  = was_setup & access;
    bad_vec[RI_HOLD]  = hit_vec[RI_HOLD] & mismatch;
    hit_vec[RI_EXCL]  = access;
    bad_vec[RI_EXCL]  = access & peer_access;
  end

  for (genvar r = 0; r < NRULE; r++) begin : g_rule
    apb_mon_rule_stat #(.CW(CW)) u_stat (
      .clk(clk), .rst_n(rst_n), .hit(hit_vec[r]), .bad(bad_vec[r]),
      .pulse(viol_pulse[r]), .sticky(viol_sticky[r]),
      .count(trig_count[r*CW +: CW])
    );
  end

  AST_ORDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !prev_enable && !prev_sel) |=> viol_pulse[RI_ORDER]) else $error("order"); // R1
  AST_SETUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sel && !prev_enable && !(sel && enable)) |=> viol_pulse[RI_SETUP]) else $error("setup"); // R2
  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sel && !prev_enable && sel && enable && addr != prev_addr) |=> viol_pulse[RI_HOLD]) else $error("hold"); // R4
  AST_EXCL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && enable && peer_sel && peer_enable) |=> viol_pulse[RI_EXCL]) else $error("excl"); // R6
  AST_EXCL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(peer_sel && peer_enable) |=> !viol_pulse[RI_EXCL]) else $error("excl false"); // R6
endmodule

// File: tb/apb_rule_monitor_tb.sv
module apb_rule_monitor_tb;
  import apb_mon_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int LIMIT = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic sel, enable, ready, write, peer_sel, peer_enable;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NRULE-1:0] viol_pulse, viol_sticky;
  logic [NRULE*CW-1:0] trig_count;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state
  logic h_sel, h_en, h_write;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata;
  int m_wait;
  logic [NRULE-1:0] e_pulse, e_sticky;
  int e_cnt [NRULE];
  string rule_tag [NRULE] = '{"R1", "R2", "R3,R10", "R4,R5", "R6"};

  apb_rule_monitor #(.AW(AW), .DW(DW), .CW(CW), .WAIT_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .ready(ready),
    .addr(addr), .write(write), .wdata(wdata), .peer_sel(peer_sel),
    .peer_enable(peer_enable), .viol_pulse(viol_pulse), .viol_sticky(viol_sticky),
    .trig_count(trig_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int cnt_of(input int r);
    return int'(trig_count[r*CW +: CW]);
  endfunction

  task automatic compare_all();
    for (int r = 0; r < NRULE; r++) begin
      chk(viol_pulse[r] == e_pulse[r], {rule_tag[r], " R8 pulse"}, viol_pulse[r], e_pulse[r]);
      chk(viol_sticky[r] == e_sticky[r], {rule_tag[r], " R8 sticky"}, viol_sticky[r], e_sticky[r]);
      chk(cnt_of(r) == e_cnt[r], {rule_tag[r], " R9 count"}, cnt_of(r), e_cnt[r]);
    end
  endtask

  task automatic model_clear();
    h_sel = 0; h_en = 0; h_write = 0; h_addr = '0; h_wdata = '0;
    m_wait = 0; e_pulse = '0; e_sticky = '0;
    for (int r = 0; r < NRULE; r++) e_cnt[r] = 0;
  endtask

  // expected results for one sampled cycle, from the rule definitions
  task automatic model_step(input logic s, e, r, input logic [AW-1:0] a,
                            input logic w, input logic [DW-1:0] d, input logic ps, pe);
    logic acc;
    logic [NRULE-1:0] hit, bad;
    acc = s & e;
    hit[0] = e && !h_en;                 bad[0] = hit[0] && !h_sel;
    hit[1] = h_sel && !h_en;             bad[1] = hit[1] && !acc;
    hit[2] = acc && (m_wait == 0);
    m_wait = (acc && !r) ? ((m_wait < 1000) ? m_wait + 1 : m_wait) : 0;
    bad[2] = (m_wait == LIMIT);
    hit[3] = h_sel && !h_en && acc;
    bad[3] = hit[3] && ((a != h_addr) || (w != h_write) || (h_write && d != h_wdata));
    hit[4] = acc;                        bad[4] = acc && ps && pe;
    for (int k = 0; k < NRULE; k++) begin
      if (hit[k] && e_cnt[k] < CMAX) e_cnt[k]++;
    end
    e_pulse = bad;
    e_sticky = e_sticky | bad;
    h_sel = s; h_en = e; h_addr = a; h_write = w; h_wdata = d;
  endtask

  task automatic cyc(input logic s, e, r, input logic [AW-1:0] a,
                     input logic w, input logic [DW-1:0] d, input logic ps, pe);
    sel = s; enable = e; ready = r; addr = a; write = w; wdata = d;
    peer_sel = ps; peer_enable = pe;
    @(posedge clk);
    model_step(s, e, r, a, w, d, ps, pe);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic apply_reset(input int n);
    rst_n = 0;
    model_clear();
    for (int i = 0; i < n; i++) begin
      sel = 1; enable = 1; ready = 0; peer_sel = 1; peer_enable = 1;
      @(negedge clk);
      compare_all(); // R7 cleared and nothing reported while reset is low
    end
    sel = 0; enable = 0; peer_sel = 0; peer_enable = 0;
    rst_n = 1;
  endtask

  // one transfer: setup then access with `waits` not-ready cycles
  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d, input int waits);
    cyc(1, 0, 0, a, w, d, 0, 0);
    for (int i = 0; i < waits; i++) cyc(1, 1, 0, a, w, d, 0, 0);
    cyc(1, 1, 1, a, w, d, 0, 0);
  endtask

  initial begin
    int seed_val;
    rst_n = 0; sel = 0; enable = 0; ready = 0; addr = '0; write = 0;
    wdata = '0; peer_sel = 0; peer_enable = 0;
    model_clear();
    seed_val = $urandom(20240611);
    @(negedge clk);
    apply_reset(3);                    // R7 reset state
    idle(2);

    xfer(16'h0010, 1, 16'h1234, 0);    // legal write, no violation
    xfer(16'h0020, 0, 16'h0000, 3);    // legal read with waits
    idle(1);
    xfer(16'h0030, 1, 16'h0001, 15);   // R3 ready at offset 15: no timeout
    idle(1);
    xfer(16'h0040, 0, 16'h0002, 22);   // R3 R10 stall past limit: one pulse
    xfer(16'h0044, 0, 16'h0002, 17);   // R10 re-armed: second pulse
    idle(1);
    cyc(1, 0, 0, 16'h0050, 1, 16'h00AA, 0, 0);   // R4 address moves
    cyc(1, 1, 1, 16'h0051, 1, 16'h00AA, 0, 0);
    cyc(1, 0, 0, 16'h0060, 1, 16'h00AA, 0, 0);   // R4 direction flips
    cyc(1, 1, 1, 16'h0060, 0, 16'h00AA, 0, 0);
    cyc(1, 0, 0, 16'h0070, 1, 16'h00AA, 0, 0);   // R5 write data moves on write
    cyc(1, 1, 1, 16'h0070, 1, 16'h00AB, 0, 0);
    cyc(1, 0, 0, 16'h0080, 0, 16'h00AA, 0, 0);   // R5 read: data ignored
    cyc(1, 1, 1, 16'h0080, 0, 16'h5555, 0, 0);
    idle(1);
    cyc(1, 1, 1, 16'h0090, 0, '0, 0, 0);         // R1 access with no setup
    idle(1);
    cyc(1, 0, 0, 16'h00A0, 0, '0, 0, 0);         // R2 setup abandoned
    idle(1);
    cyc(1, 0, 0, 16'h00B0, 0, '0, 1, 0);         // R6 peer selected only: fine
    cyc(1, 1, 0, 16'h00B0, 0, '0, 1, 1);         // R6 overlap
    cyc(1, 1, 1, 16'h00B0, 0, '0, 1, 1);         // R6 overlap again
    idle(1);
    cyc(1, 0, 0, 16'h00C0, 0, '0, 0, 0);         // R7 reset mid stall
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 16'h00C0, 0, '0, 0, 0);
    apply_reset(2);
    xfer(16'h00C4, 0, '0, 12);                   // R7 timer restarted from zero
    idle(1);

    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) != 0,
          AW'($urandom % 2), $urandom % 2, DW'($urandom % 2),
          ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    idle(2);

    // R9 saturation: long access with ready keeps counting rule 4 triggers
    cyc(1, 0, 0, 16'h0100, 0, '0, 0, 0);
    for (int i = 0; i < CMAX + 10; i++) cyc(1, 1, 1, 16'h0100, 0, '0, 0, 0);
    chk(cnt_of(RI_EXCL) == CMAX, "R9 saturated", cnt_of(RI_EXCL), CMAX);
    idle(2);

    summary();
    $finish;
  end
endmodule